// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock for an SD/MMC host from the system clock. A 10-bit control word sets an integer divider, an enable, an independent stop bit and a high-speed select. The card clock runs at the system clock divided by 2×(div+1). With div in 0..127, that spans half the system clock down to one 256th of it. The output has a 50% duty cycle at every setting.

Alongside the clock, the block gives one-cycle strobes that mark each rising and each falling card-clock edge. The command and data shifters use these strobes to drive and sample their lines. Enable, stop and divider changes are all applied at a single point: the instant the card clock would next rise. A pulse on the card lines is therefore never shortened. A card-power word and a bus-width word are kept beside the control word as plain read/write storage.

Top module: `sd_clk_gen`

## Requirements
- R1: After reset, `sd_clk`, `sd_rise`, `sd_fall` and `hs_sel` are 0, and the control word (address 0) reads 0x0000007F: divider 127, enable 0, stop 0, high-speed 0.
- R2: A write to address 0 stores bits 9:0. Reading address 0 returns those bits, with bits 31:10 read as 0. Bits 6:0 are the divider, bit 7 is enable, bit 8 is stop, and bit 9 is high-speed.
- R3: While running with divider d, every high phase and every low phase of `sd_clk` lasts exactly d+1 system cycles, for any d from 0 to 127.
- R4: `sd_clk` toggles only while enable is 1 and stop is 0. When either condition fails, `sd_clk` stays low from the next rising boundary onward.
- R5: Gating changes only at a rising boundary, so every high pulse, including the last one before a stop and the first one after a restart, lasts d+1 cycles.
- R6: A divider written while the clock runs does not alter the period already under way. The high and low phase in progress keep the old length, and the new length starts with the next high phase.
- R7: `sd_rise` is 1 exactly in the first cycle `sd_clk` is high. `sd_fall` is 1 exactly in the first cycle `sd_clk` is low after a high pulse. Neither strobe fires while the clock is gated.
- R8: `hs_sel` equals bit 9 of the control word from the cycle after the write.
- R9: Address 1 stores bits 4:0 (card power) and address 2 stores bits 2:0 (bus width). Other bits read as 0. Address 3 reads 0, and writes to it are ignored. None of these addresses affects the card clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 clock control, 1 power, 2 bus width |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Combinational read data for `rd_addr` |
| sd_clk | output | 1 | Card clock, registered |
| sd_rise | output | 1 | One-cycle strobe in the first high cycle of `sd_clk` |
| sd_fall | output | 1 | One-cycle strobe in the first low cycle of `sd_clk` |
| hs_sel | output | 1 | High-speed select from the control word |

## Verification
A write lands at the next system-clock edge. Readback and `hs_sel` are therefore checked one cycle after the write. The card clock follows the write only at a later rising boundary, which can be up to 2×(d+1) cycles away. For that reason the bench counts completed high and low phases rather than absolute cycles. After any divider change it discards two rising boundaries before measuring lengths. For R6 it instead measures the phases that straddle the write, to see that the old length completes. The strobes are due in the same cycle as the level change they mark. A monitor compares them to the sampled level every cycle, at the falling system-clock edge.

// File: rtl/sd_clk_gen.sv
module sd_clk_gen #(
  parameter int DIV_W  = 7,
  parameter int REG_W  = 32,
  parameter int PWR_W  = 5,
  parameter int BUSW_W = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              sd_clk,
  output logic              sd_rise,
  output logic              sd_fall,
  output logic              hs_sel
);
  localparam int EN_BIT  = DIV_W;
  localparam int OFF_BIT = DIV_W + 1;
  localparam int HS_BIT  = DIV_W + 2;
  localparam int CTRL_W  = DIV_W + 3;
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'({DIV_W{1'b1}});

  logic [CTRL_W-1:0] ctrl_q;
  logic [PWR_W-1:0]  pwr_q;
  logic [BUSW_W-1:0] busw_q;
  logic [DIV_W-1:0]  cnt_q, div_q;
  logic              phase_q, run_q;

  wire unused_wr_bits = ^wr_data[REG_W-1:CTRL_W];

  wire tick    = (cnt_q == div_q);
  wire load    = tick & ~phase_q;
  wire run_req = ctrl_q[EN_BIT] & ~ctrl_q[OFF_BIT];
  wire phase_d = tick ? ~phase_q : phase_q;
  wire run_d   = load ? run_req : run_q;

  assign hs_sel = ctrl_q[HS_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      pwr_q  <= '0;
      busw_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(0): ctrl_q <= wr_data[CTRL_W-1:0];
        ADDR_W'(1): pwr_q  <= wr_data[PWR_W-1:0];
        ADDR_W'(2): busw_q <= wr_data[BUSW_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      div_q   <= '1;
      phase_q <= 1'b0;
      run_q   <= 1'b0;
      sd_clk  <= 1'b0;
      sd_rise <= 1'b0;
      sd_fall <= 1'b0;
    end else begin
      cnt_q   <= tick ? '0 : cnt_q + 1'b1;
      phase_q <= phase_d;
      run_q   <= run_d;
      if (load) div_q <= ctrl_q[DIV_W-1:0];
      sd_clk  <= phase_d & run_d;
      sd_rise <= load & run_req;
      sd_fall <= tick & phase_q & run_q;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(0): rd_data[CTRL_W-1:0] = ctrl_q;
      ADDR_W'(1): rd_data[PWR_W-1:0]  = pwr_q;
      ADDR_W'(2): rd_data[BUSW_W-1:0] = busw_q;
      default: ;
    endcase
  end

  logic [DIV_W-1:0] hlen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) hlen_q <= '0;
    else        hlen_q <= sd_clk ? hlen_q + 1'b1 : '0;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q);
  assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_clk) |-> ($past(hlen_q) == $past(div_q)));
  assert_gated_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !sd_clk);
  assert_div_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_q) |-> (phase_q && cnt_q == '0));
  assert_rise_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_rise |-> (sd_clk && !$past(sd_clk)));
  assert_fall_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_fall |-> (!sd_clk && $past(sd_clk)));
  assert_edge_marked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_clk) |-> sd_rise);
endmodule

// File: tb/test_sd_clk_gen.sv
`timescale 1ns/1ps
module test_sd_clk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        sd_clk, sd_rise, sd_fall, hs_sel;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sd_clk_gen i_sd_clk_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sd_clk(sd_clk), .sd_rise(sd_rise),
    .sd_fall(sd_fall), .hs_sel(hs_sel)
  );

  // phase-length monitor, sampled at the falling system edge
  logic prev = 1'b0;
  int run_len = 0, last_hi = 0, last_lo = 0, hi_cnt = 0, lo_cnt = 0, strobe_err = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sd_rise !== (sd_clk & ~prev) || sd_fall !== (~sd_clk & prev)) begin
        strobe_err++;
        checks++; fails++;
        $display("FAIL R7 strobes: rise=%0b fall=%0b expected rise=%0b fall=%0b",
                 sd_rise, sd_fall, sd_clk & ~prev, ~sd_clk & prev);
      end
      if (sd_clk != prev) begin
        if (prev) begin last_hi = run_len; hi_cnt++; end
        else      begin last_lo = run_len; lo_cnt++; end
        run_len = 1;
      end else run_len++;
      prev = sd_clk;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic wait_hi(input int n);
    int h0 = hi_cnt;
    while (hi_cnt < h0 + n) @(posedge clk);
  endtask

  task automatic wait_lo(input int n);
    int l0 = lo_cnt;
    while (lo_cnt < l0 + n) @(posedge clk);
  endtask

  function automatic int half_len(input int d);
    return d + 1;
  endfunction

  task automatic measure(input int d, input string req);
    wait_hi(1);
    chk(last_hi == half_len(d), req, "high phase length", last_hi, half_len(d));
    wait_lo(1);
    chk(last_lo == half_len(d), req, "low phase length", last_lo, half_len(d));
  endtask

  task automatic set_and_measure(input int d, input bit hs, input string req);
    logic [31:0] v;
    logic [31:0] w = {22'h3FFFFF, hs, 1'b0, 1'b1, 7'(d)};
    wr(2'd0, w);
    chk(hs_sel == hs, "R8", "hs_sel", hs_sel, hs);
    rd(2'd0, v);
    chk(v == (w & 32'h3FF), "R2", "control readback", v, w & 32'h3FF);
    wait_lo(2);
    measure(d, req);
  endtask

  task automatic count_highs(input int n, output int highs);
    highs = 0;
    repeat (n) begin @(negedge clk); if (sd_clk) highs++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog: run length 200000 cycles, expected completion earlier");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int highs, h0, d;
    void'($urandom(32'h5EED));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(sd_clk == 0 && sd_rise == 0 && sd_fall == 0, "R1", "outputs after reset",
        {sd_clk, sd_rise, sd_fall}, 0);
    chk(hs_sel == 0, "R1", "hs_sel after reset", hs_sel, 0);
    rd(2'd0, v);
    chk(v == 32'h7F, "R1", "control after reset", v, 32'h7F);
    count_highs(600, highs);
    chk(highs == 0, "R4", "highs while enable is 0 after reset", highs, 0);

    // R2 readback masks upper bits: 0xFFFFFC85 -> div 5, enable 1
    wr(2'd0, 32'hFFFF_FC85);
    rd(2'd0, v);
    chk(v == 32'h085, "R2", "masked readback", v, 32'h085);
    wait_lo(2);
    measure(5, "R3");

    // R3 boundary settings
    set_and_measure(0, 1'b0, "R3");
    set_and_measure(127, 1'b1, "R3");

    // R6 divider change during a high phase: old 9 completes, then 3
    set_and_measure(9, 1'b0, "R3");
    wait_lo(1);
    wr(2'd0, 32'h083);
    wait_hi(1);
    chk(last_hi == 10, "R6", "high in progress keeps old length", last_hi, 10);
    wait_lo(1);
    chk(last_lo == 10, "R6", "low in progress keeps old length", last_lo, 10);
    wait_hi(1);
    chk(last_hi == 4, "R6", "next high uses new length", last_hi, 4);

    // R4/R5 stop bit by read-modify-write
    set_and_measure(6, 1'b0, "R3");
    rd(2'd0, v);
    h0 = hi_cnt;
    wr(2'd0, v | 32'h100);
    repeat (4 * 7 + 4) @(posedge clk);
    if (hi_cnt > h0)
      chk(last_hi == 7, "R5", "last high before stop", last_hi, 7);
    count_highs(4 * 7 + 4, highs);
    chk(highs == 0, "R4", "highs while stopped", highs, 0);
    rd(2'd0, v);
    chk(v == 32'h186, "R2", "stop keeps other fields", v, 32'h186);
    wr(2'd0, v & ~32'h100);
    wait_hi(1);
    chk(last_hi == 7, "R5", "first high after restart", last_hi, 7);
    wait_lo(1);
    chk(last_lo == 7, "R3", "low after restart", last_lo, 7);

    // R4 enable cleared
    wr(2'd0, 32'h006);
    repeat (4 * 7 + 4) @(posedge clk);
    count_highs(4 * 7 + 4, highs);
    chk(highs == 0, "R4", "highs while enable is 0", highs, 0);

    // R9 plain storage
    set_and_measure(4, 1'b0, "R3");
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd1, v); chk(v == 32'h1F, "R9", "power storage", v, 32'h1F);
    rd(2'd2, v); chk(v == 32'h7,  "R9", "bus-width storage", v, 32'h7);
    rd(2'd3, v); chk(v == 32'h0,  "R9", "address 3 reads zero", v, 0);
    rd(2'd0, v); chk(v == 32'h084, "R9", "control untouched by other writes", v, 32'h084);
    measure(4, "R9");

    // random settings
    for (int i = 0; i < 6; i++) begin
      d = int'($urandom % 128);
      set_and_measure(d, 1'($urandom), "R3");
    end

    chk(strobe_err == 0, "R7", "strobe mismatches", strobe_err, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule